// File: doc/BRIEF.md
# Runahead Mode Controller

This controller decides when a core stops stalling on a long cache miss and instead runs ahead speculatively. When the oldest instruction in the window is blocked on a long-latency miss, the controller saves a copy of the architectural register values and switches to runahead mode. It also marks the missing load's destination register as invalid. Younger instructions then keep flowing. Each register carries an invalid (INV) flag. An instruction that reads an INV register is dropped and passes the flag on to its destination. A load or store whose address register is valid sends its address out as a prefetch.

When the original miss data comes back, the controller leaves runahead mode. It copies the saved values back into the register file, clears every INV flag, and raises a one-cycle restore pulse together with the PC of the load that missed, so that the core can restart from that load. Nothing written while running ahead survives the return to normal mode. A read port shows the register file contents one cycle after the index is given.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the mode flag, prefetch valid, drop and restore outputs are all 0, and every register reads 0.
- R2: Runahead mode is entered only from normal mode, in the cycle after `oldest_miss` is 1. Any instruction presented in that entry cycle is ignored: it writes no register and produces no prefetch or drop.
- R3: On entry the register values are saved. The cycle after exit, every register reads back the value it held when mode was entered.
- R4: On entry the register at `oldest_dst` becomes INV. In runahead mode, an instruction with `ins_wr`=1 makes its destination INV if either source is INV, and makes it valid again if both sources are valid.
- R5: In runahead mode, an instruction with either source INV sets `drop`=1 in the following cycle and writes no register value.
- R6: In runahead mode, an instruction with `ins_mem`=1 whose address source (`ins_src1`) is valid sets `pf_valid`=1 and `pf_addr`=`ins_addr` in the following cycle. If that source is INV, no prefetch is issued. In normal mode no prefetch is ever issued.
- R7: In runahead mode, a load (`ins_mem`=1, `ins_load`=1) flagged `ins_miss`=1 with valid sources issues its prefetch, is not dropped, and makes its destination INV without writing a value.
- R8: When `fill_ret` is 1 in runahead mode, in the next cycle the mode flag is 0 and `restore` is 1 for exactly one cycle, with `restart_pc` equal to the `oldest_pc` captured at entry. All INV flags are cleared. Any instruction presented in that cycle is ignored.
- R9: `fill_ret` in normal mode has no effect: no restore pulse, no mode change and no register change.
- R10: In normal mode an instruction with `ins_wr`=1 writes `ins_data` to `ins_dst`. Values written in runahead mode are visible only while in runahead mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | An instruction is presented this cycle |
| ins_src1 | input | 4 | First source index (address source for memory ops) |
| ins_src2 | input | 4 | Second source index |
| ins_dst | input | 4 | Destination index |
| ins_wr | input | 1 | Instruction writes its destination |
| ins_mem | input | 1 | Instruction is a load or store |
| ins_load | input | 1 | Memory op is a load |
| ins_miss | input | 1 | Load hits a long-latency miss |
| ins_addr | input | 32 | Computed memory address |
| ins_data | input | 16 | Result value to write |
| oldest_miss | input | 1 | Oldest instruction is stalled on a long miss |
| oldest_pc | input | 32 | PC of that oldest instruction |
| oldest_dst | input | 4 | Destination register of that oldest load |
| fill_ret | input | 1 | Data of the original miss has returned |
| rd_idx | input | 4 | Register read index |
| ra_mode | output | 1 | 1 while in runahead mode |
| pf_valid | output | 1 | Prefetch request valid |
| pf_addr | output | 32 | Prefetch address |
| drop | output | 1 | Previous instruction was dropped as INV |
| restore | output | 1 | One-cycle pulse when the saved state is restored |
| restart_pc | output | 32 | PC to restart from after restore |
| rd_data | output | 16 | Register value at `rd_idx`, one cycle later |

## Verification
The bench repeats entry once for every possible missing-load destination. For each one it sweeps all sixteen registers as sources, so that exactly one register drops and the other fifteen prefetch; a design that marked the wrong flag, or none, fails at once. It then chains INV through a dependent write, makes that register valid again, and raises a second miss in runahead mode. A design that stalled on that miss, or forgot to make its destination INV, would show a missing prefetch or a missing drop. Instructions presented in the entry and exit cycles, and fills that arrive in normal mode, are each checked through readback. This catches a design that leaked a write into the saved state, or restored at the wrong time.

// File: rtl/ra_pkg.sv
package ra_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_AHEAD  = 1'b1
  } ra_mode_e;
endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm #(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           oldest_miss,
  input  logic [PCW-1:0] oldest_pc,
  input  logic           fill_ret,
  output logic           mode_o,
  output logic           enter_o,
  output logic           leave_o,
  output logic           restore_o,
  output logic [PCW-1:0] restart_pc_o
);
  import ra_pkg::*;

  ra_mode_e       state_q;
  logic [PCW-1:0] miss_pc_q;
  logic           restore_q;

  assign enter_o      = (state_q == MODE_NORMAL) && oldest_miss;
  assign leave_o      = (state_q == MODE_AHEAD) && fill_ret;
  assign mode_o       = (state_q == MODE_AHEAD);
  assign restore_o    = restore_q;
  assign restart_pc_o = miss_pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= MODE_NORMAL;
      miss_pc_q <= '0;
      restore_q <= 1'b0;
    end else begin
      restore_q <= leave_o;
      if (enter_o) begin
        state_q   <= MODE_AHEAD;
        miss_pc_q <= oldest_pc;
      end else if (leave_o) begin
        state_q <= MODE_NORMAL;
      end
    end
  end

  // R2
  entry_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_o) |-> $past(oldest_miss));
  // R8
  restore_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    restore_o |=> !restore_o);
  // R8
  exit_restore_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_o) |-> restore_o);
  // R9
  idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_o && fill_ret) |=> !restore_o);
endmodule

// File: rtl/ra_inv_track.sv
module ra_inv_track #(
  parameter int NREG = 16,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_i,
  input  logic            enter_i,
  input  logic            leave_i,
  input  logic [RIDX-1:0] miss_dst_i,
  input  logic            upd_i,
  input  logic            wr_i,
  input  logic            new_miss_i,
  input  logic [RIDX-1:0] s1_i,
  input  logic [RIDX-1:0] s2_i,
  input  logic [RIDX-1:0] dst_i,
  output logic            s1_inv_o,
  output logic            s2_inv_o
);
  logic [NREG-1:0] inv_q;

  assign s1_inv_o = inv_q[s1_i];
  assign s2_inv_o = inv_q[s2_i];

  always_ff @(posedge clk) begin
    if (rst || leave_i) begin
      inv_q <= '0;
    end else if (enter_i) begin
      inv_q[miss_dst_i] <= 1'b1;
    end else if (upd_i && wr_i) begin
      inv_q[dst_i] <= s1_inv_o | s2_inv_o | new_miss_i;
    end
  end

  // R8
  inv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_i |-> (inv_q == '0));
  // R4
  inv_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_i) |-> ($countones(inv_q) == 1));
endmodule

// File: rtl/ra_regfile.sv
module ra_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_i,
  input  logic            enter_i,
  input  logic            leave_i,
  input  logic            we_i,
  input  logic [RIDX-1:0] waddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [RIDX-1:0] rd_idx_i,
  output logic [DW-1:0]   rd_data_o
);
  logic [NREG-1:0][DW-1:0] arch_q;
  logic [NREG-1:0][DW-1:0] ckpt_q;
  logic [DW-1:0]           rd_q;

  assign rd_data_o = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arch_q <= '0;
      ckpt_q <= '0;
      rd_q   <= '0;
    end else begin
      rd_q <= arch_q[rd_idx_i];
      if (enter_i) ckpt_q <= arch_q;
      if (leave_i) begin
        arch_q <= ckpt_q;
      end else if (we_i) begin
        arch_q[waddr_i] <= wdata_i;
      end
    end
  end

  // R3
  ckpt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i && $past(mode_i)) |-> $stable(ckpt_q));
  // R3
  restore_copy_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_i) |-> (arch_q == $past(ckpt_q)));
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl #(
  parameter int NREG = 16,
  parameter int DW   = 16,
  parameter int AW   = 32,
  parameter int PCW  = 32,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  input  logic [RIDX-1:0] ins_src1,
  input  logic [RIDX-1:0] ins_src2,
  input  logic [RIDX-1:0] ins_dst,
  input  logic            ins_wr,
  input  logic            ins_mem,
  input  logic            ins_load,
  input  logic            ins_miss,
  input  logic [AW-1:0]   ins_addr,
  input  logic [DW-1:0]   ins_data,
  input  logic            oldest_miss,
  input  logic [PCW-1:0]  oldest_pc,
  input  logic [RIDX-1:0] oldest_dst,
  input  logic            fill_ret,
  input  logic [RIDX-1:0] rd_idx,
  output logic            ra_mode,
  output logic            pf_valid,
  output logic [AW-1:0]   pf_addr,
  output logic            drop,
  output logic            restore,
  output logic [PCW-1:0]  restart_pc,
  output logic [DW-1:0]   rd_data
);
  logic mode, enter, leave;
  logic s1_inv, s2_inv, src_inv;
  logic run_ins, norm_ins, new_miss, we;
  logic pf_q, drop_q;
  logic [AW-1:0] pf_addr_q;

  ra_mode_fsm #(.PCW(PCW)) u_fsm (
    .clk(clk), .rst(rst), .oldest_miss(oldest_miss), .oldest_pc(oldest_pc),
    .fill_ret(fill_ret), .mode_o(mode), .enter_o(enter), .leave_o(leave),
    .restore_o(restore), .restart_pc_o(restart_pc)
  );

  assign run_ins  = ins_valid && mode && !fill_ret;
  assign norm_ins = ins_valid && !mode && !oldest_miss;
  assign new_miss = ins_mem && ins_load && ins_miss;
  assign src_inv  = s1_inv | s2_inv;
  assign we       = ins_wr && (norm_ins || (run_ins && !src_inv && !new_miss));

  ra_inv_track #(.NREG(NREG)) u_inv (
    .clk(clk), .rst(rst), .mode_i(mode), .enter_i(enter), .leave_i(leave),
    .miss_dst_i(oldest_dst), .upd_i(run_ins), .wr_i(ins_wr),
    .new_miss_i(new_miss), .s1_i(ins_src1), .s2_i(ins_src2),
    .dst_i(ins_dst), .s1_inv_o(s1_inv), .s2_inv_o(s2_inv)
  );

  ra_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst(rst), .mode_i(mode), .enter_i(enter), .leave_i(leave),
    .we_i(we), .waddr_i(ins_dst), .wdata_i(ins_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q      <= 1'b0;
      pf_addr_q <= '0;
      drop_q    <= 1'b0;
    end else begin
      pf_q   <= run_ins && ins_mem && !s1_inv;
      drop_q <= run_ins && src_inv;
      if (run_ins && ins_mem && !s1_inv) pf_addr_q <= ins_addr;
    end
  end

  assign ra_mode  = mode;
  assign pf_valid = pf_q;
  assign pf_addr  = pf_addr_q;
  assign drop     = drop_q;

  // R6
  pf_mode_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> $past(ra_mode));
  // R5
  drop_mode_chk: assert property (@(posedge clk) disable iff (rst)
    drop |-> $past(ra_mode));
  // R8
  exit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    restore |-> (!pf_valid && !drop));
endmodule

// File: tb/sim_runahead_ctrl.sv
module sim_runahead_ctrl;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic ins_valid, ins_wr, ins_mem, ins_load, ins_miss;
  logic [3:0] ins_src1, ins_src2, ins_dst, oldest_dst, rd_idx;
  logic [31:0] ins_addr, oldest_pc;
  logic [15:0] ins_data;
  logic oldest_miss, fill_ret;
  logic ra_mode, pf_valid, drop, restore;
  logic [31:0] pf_addr, restart_pc;
  logic [15:0] rd_data;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [15:0] m_arch [16];
  logic [15:0] m_ckpt [16];
  logic        m_inv  [16];
  logic        m_mode;
  logic [31:0] m_pc;

  always #(PERIOD/2) clk = ~clk;

  runahead_ctrl u0 (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_src1(ins_src1),
    .ins_src2(ins_src2), .ins_dst(ins_dst), .ins_wr(ins_wr), .ins_mem(ins_mem),
    .ins_load(ins_load), .ins_miss(ins_miss), .ins_addr(ins_addr),
    .ins_data(ins_data), .oldest_miss(oldest_miss), .oldest_pc(oldest_pc),
    .oldest_dst(oldest_dst), .fill_ret(fill_ret), .rd_idx(rd_idx),
    .ra_mode(ra_mode), .pf_valid(pf_valid), .pf_addr(pf_addr), .drop(drop),
    .restore(restore), .restart_pc(restart_pc), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 0; ins_wr = 0; ins_mem = 0; ins_load = 0; ins_miss = 0;
    ins_src1 = 0; ins_src2 = 0; ins_dst = 0; ins_addr = 0; ins_data = 0;
    oldest_miss = 0; oldest_pc = 0; oldest_dst = 0; fill_ret = 0; rd_idx = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readback(input int r, input string req);
    idle();
    rd_idx = 4'(r);
    cyc();
    chk(req, {16'h0, rd_data}, {16'h0, m_arch[r]});
  endtask

  task automatic ins(input int s1, input int s2, input int d, input bit wr,
                     input bit mem, input bit ld, input bit ms,
                     input logic [31:0] addr, input logic [15:0] data,
                     input string req);
    logic sinv, nm, e_pf, e_drop;
    idle();
    ins_valid = 1; ins_src1 = 4'(s1); ins_src2 = 4'(s2); ins_dst = 4'(d);
    ins_wr = wr; ins_mem = mem; ins_load = ld; ins_miss = ms;
    ins_addr = addr; ins_data = data;
    sinv   = m_mode && (m_inv[s1] || m_inv[s2]);
    nm     = mem && ld && ms;
    e_pf   = m_mode && mem && !m_inv[s1];
    e_drop = sinv;
    cyc();
    chk({req, " pf"}, {31'h0, pf_valid}, {31'h0, e_pf});
    if (e_pf) chk({req, " pf_addr"}, pf_addr, addr);
    chk({req, " drop"}, {31'h0, drop}, {31'h0, e_drop});
    if (m_mode) begin
      if (wr) begin
        m_inv[d] = sinv || nm;
        if (!sinv && !nm) m_arch[d] = data;
      end
    end else if (wr) begin
      m_arch[d] = data;
    end
  endtask

  task automatic enter(input logic [31:0] pc, input int d, input int stray);
    idle();
    oldest_miss = 1; oldest_pc = pc; oldest_dst = 4'(d);
    ins_valid = 1; ins_wr = 1; ins_dst = 4'(stray); ins_data = 16'hDEAD;
    ins_mem = 1; ins_addr = 32'hBAD0;
    cyc();
    chk("R2 mode on entry", {31'h0, ra_mode}, 32'h1);
    chk("R2 no pf on entry", {31'h0, pf_valid}, 32'h0);
    for (int i = 0; i < 16; i++) begin
      m_ckpt[i] = m_arch[i];
      m_inv[i]  = 1'b0;
    end
    m_inv[d] = 1'b1;
    m_mode = 1'b1;
    m_pc = pc;
    readback(stray, "R2 entry write ignored");
  endtask

  task automatic leave();
    idle();
    fill_ret = 1;
    ins_valid = 1; ins_wr = 1; ins_dst = 4'd3; ins_data = 16'hBEEF;
    ins_mem = 1; ins_addr = 32'hCAFE;
    cyc();
    chk("R8 mode cleared", {31'h0, ra_mode}, 32'h0);
    chk("R8 restore pulse", {31'h0, restore}, 32'h1);
    chk("R8 restart pc", restart_pc, m_pc);
    chk("R8 no pf on exit", {31'h0, pf_valid}, 32'h0);
    for (int i = 0; i < 16; i++) begin
      m_arch[i] = m_ckpt[i];
      m_inv[i]  = 1'b0;
    end
    m_mode = 1'b0;
    idle();
    cyc();
    chk("R8 restore one cycle", {31'h0, restore}, 32'h0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    idle();
    m_mode = 0; m_pc = 0;
    for (int i = 0; i < 16; i++) begin
      m_arch[i] = 0; m_ckpt[i] = 0; m_inv[i] = 0;
    end
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 mode", {31'h0, ra_mode}, 32'h0);
    chk("R1 pf", {31'h0, pf_valid}, 32'h0);
    chk("R1 drop", {31'h0, drop}, 32'h0);
    chk("R1 restore", {31'h0, restore}, 32'h0);
    readback(5, "R1 reg zero");

    // R10: normal writes over all registers
    for (int i = 0; i < 16; i++)
      ins(0, 0, i, 1, 0, 0, 0, 0, 16'(16'h100 + i * 7), "R10 normal write");
    for (int i = 0; i < 16; i++) readback(i, "R10 readback");
    // R6: normal mode memory op issues no prefetch
    ins(1, 2, 0, 0, 1, 1, 1, 32'h4000, 0, "R6 normal no pf");

    // R9: fill in normal mode ignored
    idle(); fill_ret = 1; cyc();
    chk("R9 no restore", {31'h0, restore}, 32'h0);
    chk("R9 mode stays", {31'h0, ra_mode}, 32'h0);
    readback(4, "R9 regs intact");

    for (int k = 0; k < 16; k++) begin
      enter(32'h1000 + 32'(k) * 4, k, (k + 9) % 16);
      // R4 R5 R6 sweep over sources
      for (int j = 0; j < 16; j++)
        ins(j, j, 0, 0, 1, 1, 0, 32'(j) * 64, 0, "R5 R6 sweep");
      // R4 propagation into a new destination
      ins(k, (k + 3) % 16, (k + 5) % 16, 1, 0, 0, 0, 0, 16'h5555, "R4 propagate");
      ins((k + 5) % 16, (k + 1) % 16, 0, 0, 1, 0, 0, 32'h2000, 0, "R4 chained inv");
      // R4 revalidate from valid sources
      ins((k + 1) % 16, (k + 2) % 16, (k + 5) % 16, 1, 0, 0, 0, 0, 16'(16'h7700 + k), "R4 revalidate");
      ins((k + 5) % 16, (k + 5) % 16, 0, 0, 1, 1, 0, 32'h3000 + 32'(k), 0, "R4 valid again");
      readback((k + 5) % 16, "R10 spec value visible");
      // R7 new miss during runahead
      ins((k + 1) % 16, (k + 1) % 16, (k + 7) % 16, 1, 1, 1, 1, 32'h8000 + 32'(k), 16'h1234, "R7 new miss");
      ins((k + 7) % 16, (k + 7) % 16, 0, 0, 1, 1, 0, 32'h9000, 0, "R7 dst inv");
      // R2: second miss signal in runahead does not re-enter
      idle(); oldest_miss = 1; oldest_pc = 32'hFFFF; cyc();
      chk("R2 no reentry", {31'h0, ra_mode}, 32'h1);
      leave();
      for (int i = 0; i < 16; i++) readback(i, "R3 state restored");
      ins(k, k, 0, 0, 0, 0, 0, 0, 0, "R8 inv cleared");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule